// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary up-counter made of 4-bit stages. All stages share one clock edge, so every count bit changes together. The count can be cleared at once by an asynchronous active-low reset. It can be preset from parallel data through an active-low synchronous load. It advances only while both count enables are high.

Each stage raises a carry when it is full and its T enable is high. That carry feeds the T enable of the next stage. The chain therefore counts as one wide binary counter, and the last carry is brought out for further cascading. The P enable goes to every stage, so it stalls the whole chain without touching the carry.

Top module: `cnt_cascade`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `carry_o` is 0 at once, with no clock edge needed.
- R2: With `load_ni` low, the rising edge copies `data_i` into `count_o`, whatever `en_p_i` and `en_t_i` are.
- R3: With `load_ni` high and both `en_p_i` and `en_t_i` high, the rising edge adds 1 to `count_o`.
- R4: With `load_ni` high and either enable low, `count_o` keeps its value across the edge.
- R5: A counting edge at the all-ones value gives 0.
- R6: `carry_o` is 1 exactly when `count_o` is all ones and `en_t_i` is 1. A change on `en_t_i` reaches `carry_o` without a clock edge.
- R7: Stage k holds bits [4k+3:4k], and its T enable is the carry of stage k-1. The chain behaves as one `STAGE_W*N_STAGES`-bit counter.
- R8: After reset and a preset to 12, successive counting edges give 13, 14, 15, 16, 17 and 18. The low stage wraps from 15 to 0 as the next stage advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| en_p_i | input | 1 | Count enable P, shared by all stages |
| en_t_i | input | 1 | Count enable T into stage 0, also gates the carry |
| data_i | input | STAGE_W*N_STAGES | Preset data |
| count_o | output | STAGE_W*N_STAGES | Count value |
| carry_o | output | 1 | Carry from the last stage |

## Verification
Load, count and hold take effect one rising edge after the inputs are set up. The bench drives the inputs on the falling edge and compares the count at the next falling edge against its own model. The carry and the reset act without a clock, so they are checked 1 ns after the input changes, well away from any edge. A clocked carry or a synchronous clear would therefore show a stale value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // load outranks the enables
  always_comb begin
    if (!load_ni)             op_o = OP_LOAD;
    else if (en_p_i && en_t_i) op_o = OP_COUNT;
    else                      op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic         en_t_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else begin
      unique case (op_i)
        OP_LOAD:  q_q <= data_i;
        OP_COUNT: q_q <= q_q + 1'b1;
        default:  q_q <= q_q;
      endcase
    end
  end

  assign q_o     = q_q;
  assign carry_o = en_t_i & (&q_q);
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade
  import cnt_pkg::*;
#(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned CNT_W   = STAGE_W * N_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             en_p_i,
  input  logic             en_t_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  logic [N_STAGES:0] t_chain;

  assign t_chain[0] = en_t_i;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    cnt_op_e op;

    cnt_ctrl u_ctrl (
      .load_ni (load_ni),
      .en_p_i  (en_p_i),
      .en_t_i  (t_chain[g]),
      .op_o    (op)
    );

    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .en_t_i  (t_chain[g]),
      .data_i  (data_i[g*STAGE_W +: STAGE_W]),
      .q_o     (count_o[g*STAGE_W +: STAGE_W]),
      .carry_o (t_chain[g+1])
    );
  end

  assign carry_o = t_chain[N_STAGES];
endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [CNT_W-1:0] data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             carry_o
);
  p_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !carry_o));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_p_i && en_t_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_p_i && en_t_i && &count_o) |=> count_o == '0);

  p_carry_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (&count_o && en_t_i));

  p_carry_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&count_o && en_t_i) |-> carry_o);
endmodule

bind cnt_cascade cnt_cascade_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_ni (load_ni),
  .en_p_i  (en_p_i),
  .en_t_i  (en_t_i),
  .data_i  (data_i),
  .count_o (count_o),
  .carry_o (carry_o)
);

// File: tb/tb_cnt_cascade.sv
`timescale 1ns/1ps
module tb_cnt_cascade;
  localparam int unsigned STAGE_W  = 4;
  localparam int unsigned N_STAGES = 2;
  localparam int unsigned W        = STAGE_W * N_STAGES;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic         en_p_i = 1'b0;
  logic         en_t_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] count_o;
  logic         carry_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] exp_cnt = '0;

  always #5 clk_i = ~clk_i;

  cnt_cascade #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) dut (
    .clk_i, .rst_ni, .load_ni, .en_p_i, .en_t_i, .data_i, .count_o, .carry_o
  );

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, logic ld_n,
                                            logic p, logic t, logic [W-1:0] d);
    if (!ld_n)      return d;
    else if (p && t) return W'(c + 1);
    else            return c;
  endfunction

  function automatic logic exp_carry(logic [W-1:0] c, logic t);
    return t && (c == {W{1'b1}});
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, model the coming posedge
  task automatic drive(logic ld_n, logic p, logic t, logic [W-1:0] d);
    load_ni = ld_n; en_p_i = p; en_t_i = t; data_i = d;
    exp_cnt = next_cnt(exp_cnt, ld_n, p, t, d);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    process::self().srandom(32'd1234);
    #2;
    check("R1 count in reset", count_o, '0);
    check("R1 carry in reset", W'(carry_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 sequence, also R2 with enables low during load
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, W'(12));
    @(negedge clk_i);
    check("R2 preset 12", count_o, W'(12));
    drive(1'b1, 1'b1, 1'b1, '0);
    for (int k = 13; k <= 18; k++) begin
      @(negedge clk_i);
      check("R8 R7 sequence", count_o, W'(k));
      drive(1'b1, 1'b1, 1'b1, '0);
    end

    // R6 carry follows T without a clock, R5 wrap
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b1, {W{1'b1}});
    @(negedge clk_i);
    drive(1'b1, 1'b0, 1'b1, '0);
    #1 check("R6 carry at full, T high", W'(carry_o), W'(1));
    en_t_i = 1'b0;
    #1 check("R6 carry drops with T", W'(carry_o), '0);
    en_t_i = 1'b1;
    #1 check("R6 carry rises with T", W'(carry_o), W'(1));
    @(negedge clk_i);
    check("R4 hold with P low", count_o, {W{1'b1}});
    drive(1'b1, 1'b1, 1'b1, '0);
    @(negedge clk_i);
    check("R5 wrap to zero", count_o, '0);
    #1 check("R6 carry low after wrap", W'(carry_o), '0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic ld_n, p, t;
      ld_n = ($urandom_range(0, 9) != 0);
      p    = ($urandom_range(0, 3) != 0);
      t    = ($urandom_range(0, 3) != 0);
      drive(ld_n, p, t, W'($urandom));
      #1 check("R6 carry", W'(carry_o), W'(exp_carry(count_o, t)));
      @(negedge clk_i);
      check("R2 R3 R4 R7 random", count_o, exp_cnt);
    end

    // R1 asynchronous clear mid-cycle
    drive(1'b0, 1'b0, 1'b0, W'(8'hA5));
    @(negedge clk_i);
    check("R2 load before clear", count_o, W'(8'hA5));
    drive(1'b1, 1'b1, 1'b1, '0);
    #2 rst_ni = 1'b0;
    #1 check("R1 async clear", count_o, '0);
    check("R1 carry in clear", W'(carry_o), '0);
    exp_cnt = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 held in clear", count_o, '0);
    drive(1'b1, 1'b1, 1'b1, '0);
    @(negedge clk_i);
    check("R3 count after clear", count_o, W'(1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule